// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block keeps the tag and access-permission state for a set-associative cache. It stores no data. Each way of each set holds a line tag and a two-bit permission. A permission of "none" marks the way empty. A single command port takes one request per cycle: access, allocate, free, permission update, availability query and victim probe. Each request returns a registered response on the following cycle. The response gives a hit flag, a way number, a permission, an error flag and, for a probe, the full address of the line the replacement policy would evict.

A request address is split into three parts. The low bits are the line offset, which must be zero. The next bits are the set index, and the bits above them form the tag. An access is a hit only when the tag is found and the line's permission allows the request kind. A read-only line therefore serves loads and instruction fetches but refuses stores. The replacement tracker is updated on every access that finds its tag and on every successful allocation. A parameter selects the tracker: true LRU (the default) or tree pseudo-LRU.

Top module: `tdir_top`

## Requirements
- R1: The set index is `cmd_addr[OFFSET_W +: SET_W]` and the tag is the address bits above it. Lines with equal tags in different sets are independent, and only line-aligned addresses (offset bits zero) are presented.
- R2: Permission codes are 0 none/empty, 1 invalid, 2 read-only and 3 read-write. Tag search skips ways whose permission is 0, so a line whose permission is set to 0 is no longer found and its way counts as free.
- R3: Access (op 1) with kind 0 load, 1 fetch or 2 store: rsp_hit is 1 when the tag is found with permission 3, or with permission 2 and kind 0 or 1. rsp_way and rsp_perm report the found way and its permission, or 0 and 0 when the tag is absent.
- R4: Every access that finds its tag marks that way most recently used, including accesses that the permission check turns into a miss.
- R5: Availability query (op 5) returns rsp_hit=1 when the set holds the tag or has a free way. rsp_way is the found way or, failing that, the lowest free way. It changes no state.
- R6: Allocation (op 2) writes the tag into the lowest-numbered free way with permission 1, marks that way most recently used, and responds with that way and permission 1.
- R7: Allocation of a tag already present, or into a set with no free way, sets rsp_error and changes no state.
- R8: Free (op 3) of a present tag empties its way and reports rsp_hit=1, the way and its old permission. Free of an absent tag sets rsp_error.
- R9: Probe (op 6) on a full set returns in rsp_victim the line address {tag, set, zero offset} of the least recently used way, together with that way and its permission. After reset, way 0 ranks most recent and the highest way least recent. Probe on a set with a free way sets rsp_error.
- R10: Permission update (op 4) of a present tag writes cmd_perm and reports rsp_hit=1, the way and the new permission, and the new value is visible to the next command. Update of an absent tag sets rsp_error.
- R11: rsp_valid is 1 exactly one cycle after a cycle with cmd_valid=1 and 0 otherwise. Response fields not named for an op are 0, and reset empties every way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (1 access, 2 allocate, 3 free, 4 permission update, 5 availability, 6 probe) |
| cmd_kind | input | 2 | Access kind (0 load, 1 fetch, 2 store) |
| cmd_addr | input | ADDR_W (32) | Line-aligned address |
| cmd_perm | input | 2 | New permission for an update |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Hit, success or availability result |
| rsp_way | output | WAY_W (2) | Way selected by the command |
| rsp_perm | output | 2 | Permission reported for that way |
| rsp_error | output | 1 | Command could not be carried out |
| rsp_victim | output | ADDR_W (32) | Probe victim line address |

## Verification
The bench targets a read-only line hit by a store. A design that skips the permission check would report a hit here, and one that skips the replacement update on that miss would then name the wrong probe victim. It allocates a duplicate tag and allocates into a full set; a faulty design would place a second copy or overwrite a valid way. It frees a middle way and checks that the next allocation reuses that way rather than a higher free one. It also sets a permission to none and checks that the line drops out of later searches. A random mix of commands over two sets, each checked against a behavioural model that ranks ways by timestamp, exposes errors in LRU ordering and in the index and tag split.

// File: rtl/tdir_pkg.sv
package tdir_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_INV  = 2'd1,
    PERM_RO   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ACCESS  = 3'd1,
    OP_ALLOC   = 3'd2,
    OP_FREE    = 3'd3,
    OP_SETPERM = 3'd4,
    OP_AVAIL   = 3'd5,
    OP_PROBE   = 3'd6
  } op_e;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_FETCH = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  // Permission check for a found line: read-write serves all kinds,
  // read-only serves loads and fetches only.
  function automatic logic perm_allows(input logic [1:0] perm, input logic [1:0] kind);
    logic rd;
    rd = (kind == KIND_LOAD) || (kind == KIND_FETCH);
    return (perm == PERM_RW) || ((perm == PERM_RO) && rd);
  endfunction

endpackage

// File: rtl/tdir_way_search.sv
module tdir_way_search
  import tdir_pkg::*;
#(
  parameter int ASSOC = 4,
  parameter int TAG_W = 22,
  localparam int WAY_W = $clog2(ASSOC)
) (
  input  logic [ASSOC-1:0][TAG_W-1:0] row_tag,
  input  logic [ASSOC-1:0][1:0]       row_perm,
  input  logic [TAG_W-1:0]            key_tag,
  output logic [ASSOC-1:0]            match_vec,
  output logic [ASSOC-1:0]            free_vec,
  output logic                        match_any,
  output logic                        free_any,
  output logic [WAY_W-1:0]            match_way,
  output logic [WAY_W-1:0]            free_way
);

  function automatic logic [WAY_W-1:0] lowest_way(input logic [ASSOC-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = ASSOC - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  for (genvar w = 0; w < ASSOC; w++) begin : g_way
    assign free_vec[w]  = (row_perm[w] == PERM_NONE);
    assign match_vec[w] = !free_vec[w] && (row_tag[w] == key_tag);
  end

  assign match_any = |match_vec;
  assign free_any  = |free_vec;
  assign match_way = lowest_way(match_vec);
  assign free_way  = lowest_way(free_vec);

endmodule

// File: rtl/tdir_repl.sv
module tdir_repl #(
  parameter int SETS     = 16,
  parameter int ASSOC    = 4,
  parameter bit USE_PLRU = 1'b0,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(ASSOC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] victim_way
);

  if (!USE_PLRU) begin : g_lru
    // Per-way age: 0 is most recent, ASSOC-1 is the eviction candidate.
    logic [ASSOC-1:0][WAY_W-1:0] age_q [SETS];
    logic [ASSOC-1:0]            oldest_vec;

    function automatic logic [WAY_W-1:0] first_way(input logic [ASSOC-1:0] v);
      logic [WAY_W-1:0] r;
      r = '0;
      for (int i = ASSOC - 1; i >= 0; i--) begin
        if (v[i]) r = WAY_W'(i);
      end
      return r;
    endfunction

    for (genvar w = 0; w < ASSOC; w++) begin : g_old
      assign oldest_vec[w] = (age_q[query_set][w] == WAY_W'(ASSOC - 1));
    end
    assign victim_way = first_way(oldest_vec);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) begin
          for (int w = 0; w < ASSOC; w++) begin
            age_q[s][w] <= WAY_W'(w);
          end
        end
      end else if (touch_en) begin
        for (int w = 0; w < ASSOC; w++) begin
          if (WAY_W'(w) == touch_way) begin
            age_q[touch_set][w] <= '0;
          end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
            age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
          end
        end
      end
    end

    // R9
    lru_single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_vec) == 1);

  end else begin : g_plru
    // Heap-ordered tree, node n stored at bit n-1; a bit of 1 points right.
    logic [ASSOC-2:0] tree_q [SETS];

    function automatic logic [WAY_W-1:0] tree_pick(input logic [ASSOC-2:0] t);
      int n;
      n = 1;
      for (int l = 0; l < WAY_W; l++) n = 2 * n + (t[n-1] ? 1 : 0);
      return WAY_W'(n - ASSOC);
    endfunction

    function automatic logic [ASSOC-2:0] tree_touch(input logic [ASSOC-2:0] t,
                                                    input logic [WAY_W-1:0] w);
      logic [ASSOC-2:0] r;
      int n;
      r = t;
      n = 1;
      for (int l = 0; l < WAY_W; l++) begin
        r[n-1] = ~w[WAY_W-1-l];
        n = 2 * n + (w[WAY_W-1-l] ? 1 : 0);
      end
      return r;
    endfunction

    assign victim_way = tree_pick(tree_q[query_set]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (touch_en) begin
        tree_q[touch_set] <= tree_touch(tree_q[touch_set], touch_way);
      end
    end
  end

endmodule

// File: rtl/tdir_top.sv
module tdir_top
  import tdir_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 6,
  parameter int NUM_LINES = 64,
  parameter int ASSOC     = 4,
  parameter bit USE_PLRU  = 1'b0,
  localparam int SETS  = NUM_LINES / ASSOC,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(ASSOC),
  localparam int TAG_W = ADDR_W - OFFSET_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        cmd_perm,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [1:0]        rsp_perm,
  output logic              rsp_error,
  output logic [ADDR_W-1:0] rsp_victim
);

  // State arrays
  logic [ASSOC-1:0][TAG_W-1:0] tag_q  [SETS];
  logic [ASSOC-1:0][1:0]       perm_q [SETS];

  // Address split
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] key_tag;
  assign set_idx = cmd_addr[OFFSET_W +: SET_W];
  assign key_tag = cmd_addr[ADDR_W-1 -: TAG_W];

  logic [ASSOC-1:0][TAG_W-1:0] row_tag;
  logic [ASSOC-1:0][1:0]       row_perm;
  assign row_tag  = tag_q[set_idx];
  assign row_perm = perm_q[set_idx];

  // Search results (named events)
  logic [ASSOC-1:0] match_vec, free_vec;
  logic             match_any, free_any;
  logic [WAY_W-1:0] match_way, free_way, victim_way;

  tdir_way_search #(.ASSOC(ASSOC), .TAG_W(TAG_W)) u_search (
    .row_tag  (row_tag),
    .row_perm (row_perm),
    .key_tag  (key_tag),
    .match_vec(match_vec),
    .free_vec (free_vec),
    .match_any(match_any),
    .free_any (free_any),
    .match_way(match_way),
    .free_way (free_way)
  );

  // Control decode
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;
  logic             wr_en, wr_tag_en;
  logic [WAY_W-1:0] wr_way;
  logic [1:0]       wr_perm;

  logic              n_hit, n_err;
  logic [WAY_W-1:0]  n_way;
  logic [1:0]        n_perm;
  logic [ADDR_W-1:0] n_victim;

  tdir_repl #(.SETS(SETS), .ASSOC(ASSOC), .USE_PLRU(USE_PLRU)) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_set (set_idx),
    .touch_way (touch_way),
    .query_set (set_idx),
    .victim_way(victim_way)
  );

  always_comb begin
    touch_en  = 1'b0;
    touch_way = '0;
    wr_en     = 1'b0;
    wr_tag_en = 1'b0;
    wr_way    = '0;
    wr_perm   = PERM_NONE;
    n_hit     = 1'b0;
    n_err     = 1'b0;
    n_way     = '0;
    n_perm    = PERM_NONE;
    n_victim  = '0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_ACCESS: begin
          if (match_any) begin
            touch_en  = 1'b1;
            touch_way = match_way;
            n_way     = match_way;
            n_perm    = row_perm[match_way];
            n_hit     = perm_allows(row_perm[match_way], cmd_kind);
          end
        end
        OP_ALLOC: begin
          if (match_any || !free_any) begin
            n_err = 1'b1;
          end else begin
            wr_en     = 1'b1;
            wr_tag_en = 1'b1;
            wr_way    = free_way;
            wr_perm   = PERM_INV;
            touch_en  = 1'b1;
            touch_way = free_way;
            n_way     = free_way;
            n_perm    = PERM_INV;
          end
        end
        OP_FREE: begin
          if (match_any) begin
            wr_en   = 1'b1;
            wr_way  = match_way;
            wr_perm = PERM_NONE;
            n_hit   = 1'b1;
            n_way   = match_way;
            n_perm  = row_perm[match_way];
          end else begin
            n_err = 1'b1;
          end
        end
        OP_SETPERM: begin
          if (match_any) begin
            wr_en   = 1'b1;
            wr_way  = match_way;
            wr_perm = cmd_perm;
            n_hit   = 1'b1;
            n_way   = match_way;
            n_perm  = cmd_perm;
          end else begin
            n_err = 1'b1;
          end
        end
        OP_AVAIL: begin
          n_hit = match_any || free_any;
          n_way = match_any ? match_way : free_way;
        end
        OP_PROBE: begin
          if (free_any) begin
            n_err = 1'b1;
          end else begin
            n_way    = victim_way;
            n_perm   = row_perm[victim_way];
            n_victim = {row_tag[victim_way], set_idx, {OFFSET_W{1'b0}}};
          end
        end
        default: ;
      endcase
    end
  end

  // Registered op and kind, kept for the response checks
  logic [2:0] rsp_op_q;
  logic [1:0] rsp_kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        perm_q[s] <= '0;
      end
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_perm   <= '0;
      rsp_error  <= 1'b0;
      rsp_victim <= '0;
      rsp_op_q   <= '0;
      rsp_kind_q <= '0;
    end else begin
      if (wr_en) begin
        perm_q[set_idx][wr_way] <= wr_perm;
        if (wr_tag_en) tag_q[set_idx][wr_way] <= key_tag;
      end
      rsp_valid  <= cmd_valid;
      rsp_hit    <= n_hit;
      rsp_way    <= n_way;
      rsp_perm   <= n_perm;
      rsp_error  <= n_err;
      rsp_victim <= n_victim;
      rsp_op_q   <= cmd_valid ? cmd_op : 3'd0;
      rsp_kind_q <= cmd_kind;
    end
  end

  // R1
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr[OFFSET_W-1:0] == '0));

  // R2
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R3
  access_hit_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && rsp_op_q == OP_ACCESS) |->
      (rsp_perm == PERM_RW || (rsp_perm == PERM_RO && rsp_kind_q != KIND_STORE)));

  // R6
  alloc_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_op_q == OP_ALLOC && !rsp_error) |-> (rsp_perm == PERM_INV && !rsp_hit));

  // R7
  dup_alloc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ALLOC && match_any) |=> rsp_error);

  // R11
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

endmodule

// File: tb/tb_tdir_top.sv
module tb_tdir_top;

  localparam int NSETS = 16;
  localparam int NWAYS = 4;
  localparam int SET_SHIFT = 6;
  localparam int TAG_SHIFT = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_kind = '0;
  logic [31:0] cmd_addr = '0;
  logic [1:0]  cmd_perm = '0;
  logic        rsp_valid, rsp_hit, rsp_error;
  logic [1:0]  rsp_way, rsp_perm;
  logic [31:0] rsp_victim;

  tdir_top #(.ADDR_W(32), .OFFSET_W(6), .NUM_LINES(64), .ASSOC(4), .USE_PLRU(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_perm(cmd_perm),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_perm(rsp_perm), .rsp_error(rsp_error), .rsp_victim(rsp_victim)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Behavioural model: tag, permission and last-use stamp per way
  int m_tag   [NSETS][NWAYS];
  int m_perm  [NSETS][NWAYS];
  int m_stamp [NSETS][NWAYS];
  int tick = 0;

  int e_hit, e_way, e_perm, e_err;
  logic [31:0] e_victim;

  task automatic chk(input string what, input string rq, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin
        m_tag[s][w] = 0; m_perm[s][w] = 0; m_stamp[s][w] = -w;
      end
    tick = 0;
  endtask

  task automatic model(input int op, input int kind, input int tg, input int st, input int pm);
    int mw, fw;
    mw = -1; fw = -1;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (m_perm[st][w] != 0 && m_tag[st][w] == tg) mw = w;
      if (m_perm[st][w] == 0) fw = w;
    end
    e_hit = 0; e_way = 0; e_perm = 0; e_err = 0; e_victim = '0;
    case (op)
      1: if (mw >= 0) begin
           e_way = mw; e_perm = m_perm[st][mw];
           e_hit = (e_perm == 3 || (e_perm == 2 && kind <= 1)) ? 1 : 0;
           tick++; m_stamp[st][mw] = tick;
         end
      2: if (mw >= 0 || fw < 0) e_err = 1;
         else begin
           m_tag[st][fw] = tg; m_perm[st][fw] = 1;
           tick++; m_stamp[st][fw] = tick;
           e_way = fw; e_perm = 1;
         end
      3: if (mw >= 0) begin
           e_hit = 1; e_way = mw; e_perm = m_perm[st][mw]; m_perm[st][mw] = 0;
         end else e_err = 1;
      4: if (mw >= 0) begin
           e_hit = 1; e_way = mw; e_perm = pm; m_perm[st][mw] = pm;
         end else e_err = 1;
      5: begin
           e_hit = (mw >= 0 || fw >= 0) ? 1 : 0;
           e_way = (mw >= 0) ? mw : ((fw >= 0) ? fw : 0);
         end
      6: if (fw >= 0) e_err = 1;
         else begin
           int v;
           v = 0;
           for (int w = 1; w < NWAYS; w++) if (m_stamp[st][w] < m_stamp[st][v]) v = w;
           e_way = v; e_perm = m_perm[st][v];
           e_victim = (32'(m_tag[st][v]) << TAG_SHIFT) | (32'(st) << SET_SHIFT);
         end
      default: ;
    endcase
  endtask

  // Called at a falling edge; drives, models, then checks one cycle later.
  task automatic issue(input int op, input int kind, input int tg, input int st,
                       input int pm, input string rq);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_kind  = 2'(kind);
    cmd_addr  = (32'(tg) << TAG_SHIFT) | (32'(st) << SET_SHIFT);
    cmd_perm  = 2'(pm);
    model(op, kind, tg, st, pm);
    @(negedge clk);
    chk("valid", "R11", int'(rsp_valid), 1);
    chk("hit", rq, int'(rsp_hit), e_hit);
    chk("way", rq, int'(rsp_way), e_way);
    chk("perm", rq, int'(rsp_perm), e_perm);
    chk("error", rq, int'(rsp_error), e_err);
    chk("victim", rq, int'(rsp_victim), int'(e_victim));
  endtask

  task automatic idle();
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("idle valid", "R11", int'(rsp_valid), 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("valid in reset", "R11", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: every way empty after reset
    issue(1, 0, 5, 2, 0, "R11");
    issue(5, 0, 5, 2, 0, "R5");
    // R6: lowest free ways in order
    issue(2, 0, 5, 2, 0, "R6");
    issue(2, 0, 7, 2, 0, "R6");
    // R7: duplicate tag
    issue(2, 0, 5, 2, 0, "R7");
    // R3: invalid line misses
    issue(1, 0, 5, 2, 0, "R3");
    // R10: update then use
    issue(4, 0, 5, 2, 2, "R10");
    issue(1, 0, 5, 2, 0, "R3");
    issue(1, 1, 5, 2, 0, "R3");
    issue(1, 2, 5, 2, 0, "R3");
    issue(4, 0, 9, 2, 3, "R10");
    issue(4, 0, 7, 2, 3, "R10");
    issue(1, 2, 7, 2, 0, "R3");
    idle();
    // R1: same tag in another set is independent
    issue(1, 0, 5, 3, 0, "R1");
    issue(2, 0, 5, 3, 0, "R1");
    // Fill set 2
    issue(2, 0, 11, 2, 0, "R6");
    issue(2, 0, 13, 2, 0, "R6");
    issue(2, 0, 15, 2, 0, "R7");
    issue(5, 0, 15, 2, 0, "R5");
    issue(5, 0, 5, 2, 0, "R5");
    issue(6, 0, 0, 2, 0, "R9");
    // R4: read-only store miss still refreshes the line
    issue(1, 2, 5, 2, 0, "R4");
    issue(6, 0, 0, 2, 0, "R4");
    issue(1, 0, 7, 2, 0, "R4");
    issue(6, 0, 0, 2, 0, "R9");
    // R8: free a middle way, then reuse it
    issue(3, 0, 7, 2, 0, "R8");
    issue(1, 0, 7, 2, 0, "R8");
    issue(3, 0, 7, 2, 0, "R8");
    issue(6, 0, 0, 2, 0, "R9");
    issue(5, 0, 15, 2, 0, "R5");
    issue(2, 0, 15, 2, 0, "R6");
    // R2: permission none drops the line from search
    issue(4, 0, 11, 2, 0, "R2");
    issue(1, 0, 11, 2, 0, "R2");
    issue(2, 0, 17, 2, 0, "R2");
    issue(6, 0, 0, 2, 0, "R9");
    idle();

    // Mixed traffic over two sets
    for (int i = 0; i < 600; i++) begin
      int op, kd, tg, st, pm;
      op = int'($urandom_range(1, 6));
      kd = int'($urandom_range(0, 2));
      tg = int'($urandom_range(0, 5));
      st = int'($urandom_range(4, 5));
      pm = int'($urandom_range(0, 3));
      issue(op, kd, tg, st, pm, "R9");
    end
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule